// File: doc/BRIEF.md
# Line Battery Debounce Monitor

This block decides whether loop battery is present on a telephone line. A one-cycle strobe marks each millisecond. On each strobe the block reads a small line-status field and sorts the reading into one of three kinds. Every bit low means no battery. Every bit high means battery. Any other pattern is treated as unreliable.

A flip of the battery decision needs a run of agreeing readings. A down-counter guards this run, and any disagreement or unreliable reading restarts it. A lost battery produces a one-cycle on-hook pulse, and a restored battery produces a one-cycle off-hook pulse. A separate counter tallies every strobe that reads no battery. Once that tally passes a long limit, a red alarm is raised. The alarm stays up until battery is restored.

Top module: `batt_watch`

## Requirements
- R1: After synchronous reset, `bat_ok` and `red_alarm` are 0, and neither event output pulses.
- R2: On a strobe, a status of all zeros reads as absent and all ones reads as present. Any other value, for example 0x5, reloads the debounce counter to DEB_LEN and does not advance the absence tally.
- R3: On a strobe that reads absent while `bat_ok` is 1 and the debounce counter is 0, `bat_ok` falls and `hook_on_evt` is high for exactly one clock, in the cycle after that strobe's edge.
- R4: On a strobe that reads present while `bat_ok` is 0 and the debounce counter is 0, `bat_ok` rises and `hook_off_evt` is high for exactly one clock. The absence tally clears at the same time.
- R5: A reading that agrees with `bat_ok` reloads the counter to DEB_LEN. Every strobe then decrements a nonzero counter, after any reload. A flip therefore needs DEB_LEN consecutive disagreeing strobes after a reload, and DEB_LEN+1 strobes after reset.
- R6: `red_alarm` rises on the strobe where the absence tally, counted since reset or since the last restore, first exceeds ALARM_LIMIT.
- R7: `red_alarm` clears on the strobe on which battery is restored (R4), and stays clear after that until R6 triggers again.
- R8: Without a strobe, changes of `line_stat` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle millisecond strobe |
| line_stat | input | NIB_W | Line status reading |
| bat_ok | output | 1 | Debounced battery present |
| hook_on_evt | output | 1 | One-clock pulse on battery loss |
| hook_off_evt | output | 1 | One-clock pulse on battery restore |
| red_alarm | output | 1 | Long battery absence alarm |

## Verification
The absence tally counts every all-zero reading, even while battery is still believed present. It is cleared only by a restore. Because of this, the on-hook event and the rise of the red alarm can land on the same strobe. The bench provokes this case by holding battery up with alternating zero and all-ones readings until the tally reaches ALARM_LIMIT+1-DEB_LEN. It then sends DEB_LEN zero readings. On the final strobe, it checks that both `hook_on_evt` and `red_alarm` rise together, and a per-clock reference model judges every cycle around that strobe.

// File: rtl/batt_pkg.sv
package batt_pkg;
  typedef enum logic [1:0] {
    RD_UNSURE  = 2'd0,
    RD_ABSENT  = 2'd1,
    RD_PRESENT = 2'd2
  } reading_t;
endpackage

// File: rtl/batt_classify.sv
module batt_classify
  import batt_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0] stat,
  output reading_t         rd
);
  always_comb begin
    if (~|stat)     rd = RD_ABSENT;
    else if (&stat) rd = RD_PRESENT;
    else            rd = RD_UNSURE;
  end
endmodule

// File: rtl/batt_debounce.sv
module batt_debounce
  import batt_pkg::*;
#(
  parameter int DEB_LEN = 80
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  reading_t rd,
  output logic     bat,
  output logic     gain_now,
  output logic     on_pulse,
  output logic     off_pulse
);
  localparam int CNT_W = $clog2(DEB_LEN + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEB_LEN);

  logic [CNT_W-1:0] cnt, cnt_mid, cnt_nxt;
  logic             lose_now, reload, at_zero;

  assign at_zero  = (cnt == '0);
  assign lose_now = tick && (rd == RD_ABSENT)  &&  bat && at_zero;
  assign gain_now = tick && (rd == RD_PRESENT) && !bat && at_zero;

  always_comb begin
    reload = 1'b0;
    if (tick) begin
      unique case (rd)
        RD_ABSENT:  reload = !bat || lose_now;
        RD_PRESENT: reload =  bat || gain_now;
        default:    reload = 1'b1;
      endcase
    end
    cnt_mid = reload ? FULL : cnt;
    if (tick && cnt_mid != '0) cnt_nxt = cnt_mid - 1'b1;
    else                       cnt_nxt = cnt_mid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bat       <= 1'b0;
      cnt       <= FULL;
      on_pulse  <= 1'b0;
      off_pulse <= 1'b0;
    end else begin
      cnt       <= cnt_nxt;
      on_pulse  <= lose_now;
      off_pulse <= gain_now;
      if (lose_now)      bat <= 1'b0;
      else if (gain_now) bat <= 1'b1;
    end
  end
endmodule

// File: rtl/batt_alarm.sv
module batt_alarm
  import batt_pkg::*;
#(
  parameter int ALARM_LIMIT = 5000
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  reading_t rd,
  input  logic     restore,
  output logic     alarm
);
  localparam int TMR_W = $clog2(ALARM_LIMIT + 2);
  localparam logic [TMR_W-1:0] LIM   = TMR_W'(ALARM_LIMIT);
  localparam logic [TMR_W-1:0] T_MAX = '1;

  logic [TMR_W-1:0] tally, tally_inc;

  assign tally_inc = (tally == T_MAX) ? tally : tally + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      tally <= '0;
      alarm <= 1'b0;
    end else if (restore) begin
      tally <= '0;
      alarm <= 1'b0;
    end else if (tick && rd == RD_ABSENT) begin
      tally <= tally_inc;
      if (tally_inc > LIM) alarm <= 1'b1;
    end
  end
endmodule

// File: rtl/batt_watch.sv
module batt_watch
  import batt_pkg::*;
#(
  parameter int NIB_W       = 4,
  parameter int DEB_LEN     = 80,
  parameter int ALARM_LIMIT = 5000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [NIB_W-1:0] line_stat,
  output logic             bat_ok,
  output logic             hook_on_evt,
  output logic             hook_off_evt,
  output logic             red_alarm
);
  reading_t rd;
  logic     gain_now;

  batt_classify #(.NIB_W(NIB_W)) u_cls (
    .stat (line_stat),
    .rd   (rd)
  );

  batt_debounce #(.DEB_LEN(DEB_LEN)) u_deb (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .rd        (rd),
    .bat       (bat_ok),
    .gain_now  (gain_now),
    .on_pulse  (hook_on_evt),
    .off_pulse (hook_off_evt)
  );

  batt_alarm #(.ALARM_LIMIT(ALARM_LIMIT)) u_alm (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .rd      (rd),
    .restore (gain_now),
    .alarm   (red_alarm)
  );
endmodule

// File: rtl/batt_watch_chk.sv
module batt_watch_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic bat,
  input logic on_evt,
  input logic off_evt,
  input logic alarm
);
  // R3
  on_evt_drop_chk: assert property (@(posedge clk) disable iff (rst)
    on_evt |-> (!bat && $past(bat)));
  // R4
  off_evt_rise_chk: assert property (@(posedge clk) disable iff (rst)
    off_evt |-> (bat && !$past(bat)));
  // R4
  rise_has_evt_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bat) |-> off_evt);
  // R3
  fall_has_evt_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bat) |-> on_evt);
  // R7
  restore_clears_chk: assert property (@(posedge clk) disable iff (rst)
    off_evt |-> !alarm);
  // R6
  alarm_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm) |-> $past(tick));
  // R8
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> ($stable(bat) && $stable(alarm) && !on_evt && !off_evt));
  // R3
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({on_evt, off_evt}));
endmodule

bind batt_watch batt_watch_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .bat     (bat_ok),
  .on_evt  (hook_on_evt),
  .off_evt (hook_off_evt),
  .alarm   (red_alarm)
);

// File: tb/tb_batt_watch.sv
`timescale 1ns/1ps
module tb_batt_watch;
  localparam int NW  = 4;
  localparam int DEB = 80;
  localparam int LIM = 5000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic [NW-1:0] stat = '0;
  logic          bat_ok, hook_on_evt, hook_off_evt, red_alarm;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  batt_watch #(.NIB_W(NW), .DEB_LEN(DEB), .ALARM_LIMIT(LIM)) dut (
    .clk(clk), .rst(rst), .tick(tick), .line_stat(stat),
    .bat_ok(bat_ok), .hook_on_evt(hook_on_evt),
    .hook_off_evt(hook_off_evt), .red_alarm(red_alarm)
  );

  // behavioural reference model
  int m_bat = 0, m_cnt = DEB, m_tally = 0, m_alarm = 0, m_on = 0, m_off = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_bat = 0; m_cnt = DEB; m_tally = 0; m_alarm = 0; m_on = 0; m_off = 0;
    end else begin
      m_on = 0; m_off = 0;
      if (tick) begin
        if (stat == '0) begin
          m_tally++;
          if (m_bat == 1 && m_cnt == 0) begin
            m_bat = 0; m_on = 1; m_cnt = DEB;
          end else if (m_bat == 0) m_cnt = DEB;
          if (m_tally > LIM) m_alarm = 1;
        end else if (stat == '1) begin
          if (m_bat == 0 && m_cnt == 0) begin
            m_bat = 1; m_off = 1; m_cnt = DEB; m_tally = 0; m_alarm = 0;
          end else if (m_bat == 1) m_cnt = DEB;
        end else m_cnt = DEB;
        if (m_cnt > 0) m_cnt--;
      end
    end
  end

  task automatic check(input string req, input string what, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R3", "model bat_ok", int'(bat_ok), m_bat);
      check("R3", "model hook_on_evt", int'(hook_on_evt), m_on);
      check("R4", "model hook_off_evt", int'(hook_off_evt), m_off);
      check("R6", "model red_alarm", int'(red_alarm), m_alarm);
    end
  end

  int seen_on, seen_off;

  // one strobe, then one idle cycle; events captured right after the strobe edge
  task automatic strobe(input logic [NW-1:0] v);
    stat = v; tick = 1'b1;
    @(negedge clk);
    seen_on = hook_on_evt; seen_off = hook_off_evt;
    tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "bat_ok reset", int'(bat_ok), 0);
    check("R1", "red_alarm reset", int'(red_alarm), 0);
    check("R1", "events reset", int'(hook_on_evt | hook_off_evt), 0);
    rst = 1'b0;
    @(negedge clk);

    // R8: status wiggles without strobe
    for (int i = 0; i < 6; i++) begin stat = NW'(i * 5); @(negedge clk); end
    check("R8", "bat_ok no strobe", int'(bat_ok), 0);
    check("R8", "events no strobe", int'(hook_on_evt | hook_off_evt), 0);

    // R5: DEB_LEN+1 present strobes needed after reset
    for (int i = 0; i < DEB; i++) strobe('1);
    check("R5", "bat_ok after DEB_LEN strobes", int'(bat_ok), 0);
    strobe('1);
    check("R4", "off pulse on restore", seen_off, 1);
    check("R5", "bat_ok after DEB_LEN+1", int'(bat_ok), 1);
    check("R4", "off pulse one clock", int'(hook_off_evt), 0);

    // R2: indeterminate reading restarts the loss run
    for (int i = 0; i < DEB - 1; i++) strobe('0);
    strobe(NW'(5));
    for (int i = 0; i < DEB - 1; i++) strobe('0);
    check("R2", "bat_ok held after 0x5 reload", int'(bat_ok), 1);
    strobe('0);
    check("R3", "on pulse at loss", seen_on, 1);
    check("R3", "bat_ok after loss", int'(bat_ok), 0);
    check("R3", "on pulse one clock", int'(hook_on_evt), 0);

    // R8 again, with battery absent
    stat = '1; repeat (4) @(negedge clk);
    check("R8", "bat_ok still low", int'(bat_ok), 0);

    // R6: tally since last restore already holds 2*DEB-1 zero readings
    for (int i = 0; i < LIM - (2 * DEB - 1); i++) strobe('0);
    check("R6", "alarm at limit", int'(red_alarm), 0);
    strobe('0);
    check("R6", "alarm past limit", int'(red_alarm), 1);

    // R7: restore clears the alarm
    for (int i = 0; i < DEB - 1; i++) strobe('1);
    check("R7", "alarm before restore", int'(red_alarm), 1);
    strobe('1);
    check("R7", "alarm cleared on restore", int'(red_alarm), 0);
    check("R4", "bat_ok restored", int'(bat_ok), 1);

    // R2: indeterminate readings do not advance the tally
    for (int i = 0; i < 40; i++) strobe(NW'(9));
    check("R2", "alarm after 0x9 run", int'(red_alarm), 0);

    // coincidence: loss event and alarm on the same strobe
    for (int i = 0; i < LIM + 1 - DEB; i++) begin strobe('0); strobe('1); end
    for (int i = 0; i < DEB - 1; i++) strobe('0);
    check("R6", "alarm one before coincidence", int'(red_alarm), 0);
    check("R3", "bat_ok one before coincidence", int'(bat_ok), 1);
    strobe('0);
    check("R3", "on pulse at coincidence", seen_on, 1);
    check("R6", "alarm at coincidence", int'(red_alarm), 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule